// File: doc/BRIEF.md
# Run-Time Width Saturating Receive Line Filter

This block cleans a noisy single-bit serial line, such as UART or LIN receive data, before a receiver samples it. The raw line first crosses into the system clock domain through a two-flop synchronizer. The synchronized level then drives an up/down counter that saturates at both ends. The counter climbs while the line reads 1 and falls while it reads 0. The cleaned output moves only when the counter reaches a limit, which gives the output hysteresis. Short disturbances therefore cannot reach the receiver.

The counter width is chosen while the block runs, by a 3-bit code that spans 4 to 11 bits. A wider counter rejects longer bursts of noise, at the cost of more latency. An enable input selects either the filtered level or the plain synchronized level. An active-low flag reports whether the counter sits at a limit. When the flag is high, the line is moving, which signals noise.

Top module: `rx_noise_filter`

## Requirements
- R1: The raw input passes through two flip-flops that reset to 1. In bypass mode, a change on `rx_async` appears on `rx_clean` after exactly two rising clock edges.
- R2: With `filt_en` = 0, `rx_clean` shows the synchronized line. With `filt_en` = 1, it shows the filter output.
- R3: A `width_sel` code of s sets the counter width to 4+s bits. The upper limit is then 2^(4+s)−1, so code 0 gives 15 and code 7 gives 2047.
- R4: The counter moves one step per clock, up while the synchronized line is 1 and down while it is 0. It holds at 0 and at the upper limit and never wraps.
- R5: The filter output goes to 1 on the edge where the counter reaches the upper limit, and goes to 0 on the edge where it reaches 0. Otherwise it holds. Suppose the counter sits at one limit and the input switches to the opposite level. The output then changes 2^(4+s)+1 edges later.
- R6: `sat_n` is 0 while the counter is at 0 or at the upper limit, and 1 otherwise. This holds whatever `filt_en` is.
- R7: While `rst` is high, the counter loads the upper limit for the current `width_sel`. The filter output loads 1, so `rx_clean` = 1 and `sat_n` = 0.
- R8: If `width_sel` changes so that the counter lies above the new limit, the counter loads the new limit on the next edge. This load takes precedence over counting.
- R9: A pulse on the line shorter than the counter range leaves the filter output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_async | input | 1 | Raw asynchronous serial line |
| filt_en | input | 1 | 1 selects the filtered path, 0 selects the synchronized bypass |
| width_sel | input | 3 | Counter width code, width = 4 + code |
| rx_clean | output | 1 | Cleaned serial line |
| sat_n | output | 1 | Low while the counter is at either limit |

## Verification
A width change can land in the same cycle as a counting step. The clamp of R8 and the count of R4 then compete for the counter. To provoke this, the bench resets at code 7 and lets the line fall so the counter is descending. It then switches to code 0 in mid-descent. The bench judges the result from the ports. `sat_n` must read 0 one edge later, `rx_clean` must still be 1, and the output must fall exactly 15 edges after the clamp. That count shows the counter restarted from 15 and not from a decremented value.

// File: rtl/nf_pkg.sv
package nf_pkg;

    localparam int NF_SEL_W  = 3;
    localparam int NF_MIN_W  = 4;
    localparam int NF_MAX_W  = NF_MIN_W + (1 << NF_SEL_W) - 1;
    localparam int NF_SYNC_N = 2;

    typedef logic [NF_MAX_W-1:0] nf_cnt_t;
    typedef logic [NF_SEL_W-1:0] nf_sel_t;

    // Limit flags for the counter's next value
    typedef struct packed {
        logic top;
        logic bottom;
    } nf_lim_t;

    // Upper limit of the counter for a width code: all ones over MIN_W+sel bits
    function automatic nf_cnt_t nf_limit(input nf_sel_t sel);
        nf_cnt_t m;
        m = '0;
        for (int i = 0; i < NF_MAX_W; i++) begin
            if (i < NF_MIN_W + int'(sel)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/nf_sync.sv
module nf_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nf_sat_counter.sv
module nf_sat_counter
    import nf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    up,
    input  nf_sel_t sel,
    output nf_cnt_t cnt_q,
    output nf_cnt_t lim,
    output nf_lim_t lim_d
);
    nf_cnt_t cnt_d;

    assign lim = nf_limit(sel);

    always_comb begin
        if (cnt_q > lim)       cnt_d = lim;              // clamp after width shrink
        else if (up)           cnt_d = (cnt_q == lim) ? cnt_q : cnt_q + nf_cnt_t'(1);
        else                   cnt_d = (cnt_q == '0)  ? cnt_q : cnt_q - nf_cnt_t'(1);
    end

    assign lim_d.top    = (cnt_d == lim);
    assign lim_d.bottom = (cnt_d == '0);

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= lim;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/nf_hyst.sv
module nf_hyst
    import nf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  nf_lim_t lim_d,
    output logic    q
);
    always_ff @(posedge clk) begin
        if (rst)               q <= 1'b1;
        else if (lim_d.top)    q <= 1'b1;
        else if (lim_d.bottom) q <= 1'b0;
    end
endmodule

// File: rtl/rx_noise_filter.sv
module rx_noise_filter
    import nf_pkg::*;
#(
    parameter int SYNC_STAGES = NF_SYNC_N
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_async,
    input  logic                filt_en,
    input  logic [NF_SEL_W-1:0] width_sel,
    output logic                rx_clean,
    output logic                sat_n
);
    logic    rx_sync;
    nf_cnt_t cnt_q;
    nf_cnt_t cur_lim;
    nf_lim_t lim_d;
    logic    filt_q;

    nf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rx_async),
        .q   (rx_sync)
    );

    nf_sat_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .up    (rx_sync),
        .sel   (width_sel),
        .cnt_q (cnt_q),
        .lim   (cur_lim),
        .lim_d (lim_d)
    );

    nf_hyst u_hyst (
        .clk   (clk),
        .rst   (rst),
        .lim_d (lim_d),
        .q     (filt_q)
    );

    assign rx_clean = filt_en ? filt_q : rx_sync;
    assign sat_n    = !((cnt_q == cur_lim) || (cnt_q == '0));
endmodule

// File: rtl/rx_noise_filter_chk.sv
module rx_noise_filter_chk
    import nf_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    rx_async,
    input logic    filt_en,
    input nf_sel_t width_sel,
    input logic    rx_clean,
    input logic    sat_n,
    input nf_cnt_t cnt_q,
    input logic    rx_sync,
    input logic    filt_q
);
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R1 / R2: bypass output is the input delayed by two edges
    a_r1_bypass_delay: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && !filt_en) |-> rx_clean == $past(rx_async, 2));

    // R4: single-step movement when the width is steady
    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && $stable(width_sel) && $past(cnt_q) <= nf_limit(width_sel))
        |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + nf_cnt_t'(1)
             || cnt_q == $past(cnt_q) - nf_cnt_t'(1)));

    // R8: counter stays in range while the width is steady
    a_r8_in_range: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && $stable(width_sel)) |-> cnt_q <= nf_limit(width_sel));

    // R5: filter output rises only at the top limit
    a_r5_rise_at_top: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && $rose(filt_q)) |-> cnt_q == nf_limit(width_sel));

    // R5: filter output falls only at zero
    a_r5_fall_at_zero: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && $fell(filt_q)) |-> cnt_q == '0);

    // R6: at a limit the filter output agrees with that limit
    a_r6_sat_agrees: assert property (@(posedge clk) disable iff (rst)
        !sat_n |-> filt_q == (cnt_q != '0));

    // R4: counter never moves against the synchronized line
    a_r4_direction: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && $stable(width_sel) && $past(rx_sync))
        |-> cnt_q >= $past(cnt_q));
endmodule

bind rx_noise_filter rx_noise_filter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_async  (rx_async),
    .filt_en   (filt_en),
    .width_sel (width_sel),
    .rx_clean  (rx_clean),
    .sat_n     (sat_n),
    .cnt_q     (cnt_q),
    .rx_sync   (rx_sync),
    .filt_q    (filt_q)
);

// File: tb/test_rx_noise_filter.sv
`timescale 1ns/1ps
module test_rx_noise_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_async = 1'b1;
    logic       filt_en = 1'b1;
    logic [2:0] width_sel = 3'd0;
    logic       rx_clean;
    logic       sat_n;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    rx_noise_filter i_rx_noise_filter (
        .clk       (clk),
        .rst       (rst),
        .rx_async  (rx_async),
        .filt_en   (filt_en),
        .width_sel (width_sel),
        .rx_clean  (rx_clean),
        .sat_n     (sat_n)
    );

    // {sel[14:12], latency[11:0]}; latency = 2^(4+sel)+1
    localparam logic [14:0] VEC [4] = '{
        {3'd0, 12'd17}, {3'd1, 12'd33}, {3'd3, 12'd129}, {3'd7, 12'd2049}
    };

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] sel, input logic en);
        width_sel = sel;
        filt_en   = en;
        rx_async  = 1'b1;
        rst       = 1'b1;
        tick(2);
        rst       = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lat;
        int ever_low;
        int ever_noisy;
        tick(1);

        // Table walk: R3, R5 latency both directions, R6 flag
        for (int v = 0; v < 4; v++) begin
            do_reset(VEC[v][14:12], 1'b1);
            lat = int'(VEC[v][11:0]);
            check("R7 reset rx_clean", int'(rx_clean), 1);
            check("R7 reset sat_n", int'(sat_n), 0);
            rx_async = 1'b0;
            tick(lat - 1);
            check("R5 fall not early", int'(rx_clean), 1);
            check("R6 mid-range flag", int'(sat_n), 1);
            tick(1);
            check("R3 R5 fall latency", int'(rx_clean), 0);
            check("R6 bottom flag", int'(sat_n), 0);
            rx_async = 1'b1;
            tick(lat - 1);
            check("R5 rise not early", int'(rx_clean), 0);
            tick(1);
            check("R3 R5 rise latency", int'(rx_clean), 1);
            check("R4 R6 top saturate", int'(sat_n), 0);
        end

        // R4: holding a level keeps the counter saturated
        tick(20);
        check("R4 hold at top", int'(sat_n), 0);

        // R1 R2: bypass path, two-edge delay, flag independent of enable
        do_reset(3'd0, 1'b0);
        rx_async = 1'b0;
        tick(1);
        check("R1 bypass after one edge", int'(rx_clean), 1);
        tick(1);
        check("R1 R2 bypass after two edges", int'(rx_clean), 0);
        tick(1);
        check("R6 flag in bypass", int'(sat_n), 1);
        filt_en = 1'b1;
        #1;
        check("R2 enable selects filter", int'(rx_clean), 1);

        // R9: short glitch is absorbed
        do_reset(3'd0, 1'b1);
        rx_async = 1'b0;
        tick(3);
        rx_async = 1'b1;
        ever_low = 0;
        ever_noisy = 0;
        for (int i = 0; i < 25; i++) begin
            tick(1);
            if (!rx_clean) ever_low = 1;
            if (sat_n) ever_noisy = 1;
        end
        check("R9 glitch rejected", ever_low, 0);
        check("R6 glitch raised flag", ever_noisy, 1);
        check("R6 flag settles", int'(sat_n), 0);

        // R3: widening leaves counter off the new limit
        width_sel = 3'd1;
        #1;
        check("R3 widen flag", int'(sat_n), 1);
        tick(16);
        check("R3 widen reaches new top", int'(sat_n), 0);
        check("R3 widen output", int'(rx_clean), 1);

        // R8: clamp during a descent takes precedence over counting
        do_reset(3'd7, 1'b1);
        rx_async = 1'b0;
        tick(5);
        width_sel = 3'd0;
        #1;
        check("R8 out of range flag", int'(sat_n), 1);
        tick(1);
        check("R8 clamp to new top", int'(sat_n), 0);
        check("R8 output kept", int'(rx_clean), 1);
        tick(14);
        check("R8 descent from clamp", int'(rx_clean), 1);
        tick(1);
        check("R8 fall after clamp", int'(rx_clean), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule